// File: doc/BRIEF.md
# Dual-Edge Enable Decade/Binary Counter

This block is a four-stage up counter that runs on a fast system clock. Its period is set at elaboration: decade mode counts 0 to 9, and binary mode counts 0 to 15. Two asynchronous control inputs decide when it counts. The counter advances when the count-clock input rises while the enable input is high. It also advances when the enable input falls while the count-clock input is low. Because the two inputs can swap roles, a ripple chain needs no extra gates. The top bit of one counter drives the enable input of the next counter, and the count-clock input of the next counter is tied low.

Each control input, and the level-sensitive clear, passes through a two-flop synchronizer. Edges are detected by comparing the synchronized value with its value one system clock earlier. The count register is the only state that can change the outputs, and all of its bits load together. A single qualifying event therefore moves the output straight from one count to the next. The output reflects an input change three system clocks after that change. A terminal-count output marks the last state of the period, for synchronous cascading. A count that lies outside the decade range returns to zero on the next event.

Top module: `dual_edge_counter`

## Requirements
- R1: After reset, `count_o` is 0 and `tc_o` is 0.
- R2: A low-to-high change of `cnt_clk_i` while `cnt_en_i` is high raises `count_o` by exactly one.
- R3: A low-to-high change of `cnt_clk_i` while `cnt_en_i` is low leaves `count_o` unchanged.
- R4: A high-to-low change of `cnt_en_i` while `cnt_clk_i` is low raises `count_o` by exactly one.
- R5: A high-to-low change of `cnt_en_i` while `cnt_clk_i` is high leaves `count_o` unchanged.
- R6: When `cnt_clk_i` rises and `cnt_en_i` falls in the same system clock, from clock low and enable high, `count_o` rises by exactly one.
- R7: With MODE = CNT_DECADE the count goes from 9 to 0. With MODE = CNT_BINARY it goes from 15 to 0.
- R8: While `clear_i` is high, `count_o` goes to 0 and stays at 0, and any count event that occurs during that time is ignored.
- R9: `tc_o` is high exactly when `count_o` is 9 in decade mode, or 15 in binary mode.
- R10: A binary counter whose `cnt_en_i` is driven by bit 3 of another counter, with its own `cnt_clk_i` tied low, advances once each time that bit falls.
- R11: Each count event changes `count_o` once, directly to its next value, with no intermediate value visible in any system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_clk_i | input | 1 | Count-clock input, asynchronous |
| cnt_en_i | input | 1 | Enable input, asynchronous, also the ripple-cascade input |
| clear_i | input | 1 | Level-sensitive clear, active high |
| count_o | output | CNT_W | Current count, bit 3 is the most significant stage |
| tc_o | output | 1 | High at the last state of the period |

## Verification
The bench runs one decade instance and one binary instance side by side on the same inputs. The first pattern toggles the count clock with enable held high, and then with enable held low; this tells a gated rising edge from an ungated one. The next patterns toggle enable with the clock held low, and then with the clock held high; this separates the falling-edge path from its blocked case. Further patterns change both inputs in one step, run long enough to wrap both periods, and raise clear while events keep arriving. A third instance is fed by bit 3 of the binary instance and shows the ripple cascade: its count is compared with the number of 15-to-0 wraps.

// File: rtl/dual_edge_counter_pkg.sv
package dual_edge_counter_pkg;

  typedef enum logic {
    CNT_BINARY = 1'b0,
    CNT_DECADE = 1'b1
  } cnt_mode_e;

  localparam int unsigned DEC_LAST = 9;

endpackage

// File: rtl/dec_reset_sync.sv
module dec_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_no = shift_q[STAGES-1];

endmodule

// File: rtl/dec_sync_chain.sv
module dec_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  always_comb begin
    st_d = {st_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/dec_event_detect.sv
module dec_event_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_s_i,
  input  logic gate_s_i,
  output logic step_o
);

  logic tick_q, tick_d;
  logic gate_q, gate_d;
  logic tick_rise;
  logic gate_fall;

  always_comb begin
    tick_d    = tick_s_i;
    gate_d    = gate_s_i;
    // previous values qualify each edge, so a simultaneous swap still counts
    tick_rise = tick_s_i & ~tick_q & gate_q;
    gate_fall = ~gate_s_i & gate_q & ~tick_q;
    step_o    = tick_rise | gate_fall;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
      gate_q <= gate_d;
    end
  end

  // R2 R4: a step only follows a change on one of the synchronized inputs
  p_step_needs_edge_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (tick_s_i != tick_q) || (gate_s_i != gate_q));

  // R3: a clock rise with enable previously low never steps unless enable also falls
  p_rise_blocked_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_q && $stable(gate_s_i)) |-> !step_o);

  // R5: an enable fall with the clock previously high never steps
  p_fall_blocked_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && tick_s_i) |-> !step_o);

endmodule

// File: rtl/dec_count_core.sv
module dec_count_core
  import dual_edge_counter_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter cnt_mode_e   MODE  = CNT_DECADE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);

  localparam logic [CNT_W-1:0] LAST =
    (MODE == CNT_DECADE) ? CNT_W'(DEC_LAST) : {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear_i | step_i;
    if (clear_i) begin
      cnt_d = '0;
    end else if (cnt_q >= LAST) begin
      // covers the wrap and any out-of-range decade state
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign tc_o    = (cnt_q == LAST);

  // R8: clear forces zero on the next edge
  p_clear_zero_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0));

  // R3 R5 R11: no event, no change
  p_hold_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> $stable(count_o));

  // R2: a step below the last state adds one
  p_inc_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step_i && (count_o < LAST)) |=> (count_o == $past(count_o) + 1'b1));

  // R7 R9: a step at terminal count returns to zero
  p_wrap_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step_i && tc_o) |=> (count_o == '0));

  if (MODE == CNT_DECADE) begin : g_dec_range
    // R7: decade counting never leaves 0..9
    p_dec_range_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o <= LAST);
  end

endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter
  import dual_edge_counter_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter cnt_mode_e   MODE        = CNT_DECADE,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_clk_i,
  input  logic             cnt_en_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);

  localparam int unsigned N_IN = 3;
  localparam int unsigned IDX_TICK  = 0;
  localparam int unsigned IDX_GATE  = 1;
  localparam int unsigned IDX_CLEAR = 2;

  logic            rst_n;
  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] sync_in;
  logic            step;

  dec_reset_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign raw_in[IDX_TICK]  = cnt_clk_i;
  assign raw_in[IDX_GATE]  = cnt_en_i;
  assign raw_in[IDX_CLEAR] = clear_i;

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    dec_sync_chain #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .d_i    (raw_in[g]),
      .q_o    (sync_in[g])
    );
  end

  dec_event_detect i_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .tick_s_i (sync_in[IDX_TICK]),
    .gate_s_i (sync_in[IDX_GATE]),
    .step_o   (step)
  );

  dec_count_core #(.CNT_W(CNT_W), .MODE(MODE)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .step_i  (step),
    .clear_i (sync_in[IDX_CLEAR]),
    .count_o (count_o),
    .tc_o    (tc_o)
  );

  // R8: while the synchronized clear stays high the count stays at zero
  p_clear_holds_r8 : assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(sync_in[IDX_CLEAR]) && sync_in[IDX_CLEAR]) |-> (count_o == '0));

endmodule

// File: tb/test_dual_edge_counter.sv
module test_dual_edge_counter;
  import dual_edge_counter_pkg::*;

  typedef struct {
    logic [3:0] dec;
    logic [3:0] bin;
    string      tag;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cclk;
  logic       cen;
  logic       clr;
  logic [3:0] dec_cnt, bin_cnt, casc_cnt;
  logic       dec_tc, bin_tc, casc_tc;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  int m_dec = 0, m_bin = 0, m_casc = 0;
  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;

  dual_edge_counter #(.CNT_W(4), .MODE(CNT_DECADE)) i_dual_edge_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_clk_i(cclk), .cnt_en_i(cen),
    .clear_i(clr), .count_o(dec_cnt), .tc_o(dec_tc));

  dual_edge_counter #(.CNT_W(4), .MODE(CNT_BINARY)) i_bin_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_clk_i(cclk), .cnt_en_i(cen),
    .clear_i(clr), .count_o(bin_cnt), .tc_o(bin_tc));

  // R10: ripple stage fed by bit 3 of the binary counter, count clock tied low
  dual_edge_counter #(.CNT_W(4), .MODE(CNT_BINARY)) i_casc_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_clk_i(1'b0), .cnt_en_i(bin_cnt[3]),
    .clear_i(clr), .count_o(casc_cnt), .tc_o(casc_tc));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_models(input string tag);
    exp_t e;
    m_dec = (m_dec >= 9) ? 0 : m_dec + 1;
    if (m_bin == 15) m_casc = (m_casc + 1) % 16;
    m_bin = (m_bin + 1) % 16;
    e.dec = 4'(m_dec);
    e.bin = 4'(m_bin);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drive(input logic nc, input logic ne, input string tag);
    logic ev;
    @(negedge clk_i);
    ev = (nc && !cclk && cen) || (!ne && cen && !cclk);
    cclk = nc;
    cen  = ne;
    if (ev && !clr) step_models(tag);
    repeat (6) @(negedge clk_i);
  endtask

  task automatic pulse_clk(input string tag);
    drive(1'b1, cen, tag);
    drive(1'b0, cen, tag);
  endtask

  // monitor: every observed change must match the next expected item
  logic [3:0] last_dec, last_bin;
  initial begin
    forever begin
      @(negedge clk_i);
      if (mon_on && (dec_cnt != last_dec || bin_cnt != last_bin)) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R3/R5 unexpected change", int'(dec_cnt), int'(last_dec));
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(dec_cnt == e.dec, {e.tag, " R11 decade count"}, int'(dec_cnt), int'(e.dec));
          check(bin_cnt == e.bin, {e.tag, " R11 binary count"}, int'(bin_cnt), int'(e.bin));
          check(dec_tc == (e.dec == 4'd9), "R9 decade tc", int'(dec_tc), int'(e.dec == 4'd9));
          check(bin_tc == (e.bin == 4'd15), "R9 binary tc", int'(bin_tc), int'(e.bin == 4'd15));
        end
        last_dec = dec_cnt;
        last_bin = bin_cnt;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    cclk   = 1'b0;
    cen    = 1'b0;
    clr    = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);

    // R1: reset state
    check(dec_cnt == 4'd0, "R1 decade count", int'(dec_cnt), 0);
    check(dec_tc == 1'b0, "R1 decade tc", int'(dec_tc), 0);
    check(bin_cnt == 4'd0, "R1 binary count", int'(bin_cnt), 0);
    check(casc_cnt == 4'd0, "R1 cascade count", int'(casc_cnt), 0);
    last_dec = dec_cnt;
    last_bin = bin_cnt;
    mon_on   = 1'b1;

    // R3: clock pulses with enable low do nothing
    for (int i = 0; i < 3; i++) pulse_clk("R3");

    // R2: enable high, clock rises count
    drive(1'b0, 1'b1, "R2");
    for (int i = 0; i < 4; i++) pulse_clk("R2");

    // R4: clock low, enable falls count
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b0, "R4");
      drive(1'b0, 1'b1, "R4");
    end

    // R5: clock high, enable falls is ignored (the rise to high counts as R2)
    drive(1'b1, 1'b1, "R2");
    drive(1'b1, 1'b0, "R5");
    drive(1'b1, 1'b1, "R5");
    drive(1'b1, 1'b0, "R5");
    drive(1'b0, 1'b0, "R5");

    // R6: clock rises and enable falls together, one step
    drive(1'b0, 1'b1, "R6");
    drive(1'b1, 1'b0, "R6");
    drive(1'b0, 1'b1, "R6");
    drive(1'b1, 1'b0, "R6");
    drive(1'b0, 1'b1, "R6");

    // R7: run both periods through their wrap
    for (int i = 0; i < 20; i++) pulse_clk("R7");

    // R8: clear overrides events and holds zero
    @(negedge clk_i);
    clr = 1'b1;
    if (m_dec != 0 || m_bin != 0) begin
      exp_t e;
      e.dec = 4'd0;
      e.bin = 4'd0;
      e.tag = "R8";
      sb_q.push_back(e);
    end
    m_dec = 0;
    m_bin = 0;
    m_casc = 0;
    repeat (8) @(negedge clk_i);
    for (int i = 0; i < 3; i++) pulse_clk("R8");
    drive(1'b0, 1'b0, "R8");
    drive(1'b0, 1'b1, "R8");
    check(dec_cnt == 4'd0, "R8 decade held", int'(dec_cnt), 0);
    check(bin_cnt == 4'd0, "R8 binary held", int'(bin_cnt), 0);
    check(casc_cnt == 4'd0, "R8 cascade held", int'(casc_cnt), 0);
    @(negedge clk_i);
    clr = 1'b0;
    repeat (8) @(negedge clk_i);

    // R10: two binary wraps advance the ripple stage twice
    for (int i = 0; i < 36; i++) begin
      pulse_clk("R10");
      if (i == 17) check(casc_cnt == 4'(m_casc), "R10 cascade after first wrap",
                         int'(casc_cnt), m_casc);
    end
    repeat (8) @(negedge clk_i);
    check(casc_cnt == 4'(m_casc), "R10 cascade count", int'(casc_cnt), m_casc);
    check(m_casc == 2, "R10 cascade model", m_casc, 2);

    repeat (8) @(negedge clk_i);
    check(sb_q.size() == 0, "R11 missing updates", sb_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule